// File: doc/BRIEF.md
# Shifter Operand Unit with Carry

This block forms the second ALU operand and the shifter carry-out for the data-processing instructions of a 32-bit load-store CPU. It takes the instruction word, the values of the operand register (selected by bits 3:0) and of the shift-amount register (selected by bits 11:8), the current program counter and the current carry flag. The operand comes from one of three forms: an 8-bit constant rotated right by an even amount, a register shifted by a 5-bit immediate, or a register shifted by the low byte of a second register. All four shift types are supported, together with their encodings for zero and for large shift amounts.

The shifting itself is combinational. Its result goes through a single registered valid/ready stage. A request is accepted on a rising clock edge when `in_valid` and `in_ready` are both high. Its operand and carry appear one cycle later with `out_valid` high. `in_ready` is high whenever the output stage is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output holds its value and new requests are refused. The register file, the ALU and the flag writeback are outside this block.

Top module: `shifter_operand_unit`

## Requirements
- R1: When instruction bit 25 is 1, the operand is the constant in bits 7:0, zero-extended and rotated right by twice the value in bits 11:8. The carry-out is the incoming carry when that rotation is 0, and result bit 31 otherwise.
- R2: When bit 25 is 0, bits 6:5 give the shift type: 00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right. If bit 4 is 1, the amount is the low 8 bits of `rs_val`, and bits 31:8 of `rs_val` have no effect. If bit 4 is 0, the amount is bits 11:7.
- R3: An immediate logical-left amount of 0 returns the operand unchanged, with the incoming carry as carry-out.
- R4: An immediate logical-right or arithmetic-right amount of 0 acts as a shift by 32. Logical right gives 0 with carry equal to operand bit 31. Arithmetic right gives every bit equal to operand bit 31, with that bit as carry.
- R5: An immediate rotate amount of 0 rotates through the carry by one place. The result is {carry_in, operand[31:1]} and the carry-out is operand bit 0.
- R6: For a shift by N from 1 to 31, the carry-out is operand bit 32−N for logical left, and operand bit N−1 for logical right, arithmetic right and rotate right.
- R7: A register amount of 0 returns the operand unchanged, with the incoming carry as carry-out, for every shift type.
- R8: A register logical shift (left or right) of exactly 32 gives 0. The carry is bit 0 for left and bit 31 for right. A register logical shift above 32 gives 0 with carry 0.
- R9: A register arithmetic-right shift of 32 or more gives every bit equal to the sign bit, with that bit as carry. A register rotate by a nonzero multiple of 32 returns the operand unchanged, with carry equal to bit 31.
- R10: When bits 3:0 equal 15 in a shifted-register form, the shifted value is `pc`+8 for an immediate amount and `pc`+12 for a register amount, in place of `rm_val`.
- R11: `in_ready` equals (not `out_valid`) or `out_ready`. An accepted request's result is presented with `out_valid` on the next cycle. While `out_valid` is high and `out_ready` is low, `operand` and `carry_out` stay stable.
- R12: While `rst_n` is low, `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be accepted |
| instr | input | 32 | Instruction word |
| rm_val | input | 32 | Value of the register selected by bits 3:0 |
| rs_val | input | 32 | Value of the register selected by bits 11:8 |
| pc | input | 32 | Current program counter |
| carry_in | input | 1 | Current carry flag |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| operand | output | 32 | Second ALU operand |
| carry_out | output | 1 | Shifter carry-out |

## Verification
The hardest situations to reach are the register-amount boundaries: amounts of exactly 32, just above 32, nonzero multiples of 32 for rotation, and a low byte of zero while the upper bytes of `rs_val` are nonzero. The vector table sets `rs_val` to each of these values directly. It also combines them with an operand index of 15, so that the program-counter offset and the shift boundary are exercised in the same request. Back-pressure is reached by holding `out_ready` low while new, different requests are offered. The test then confirms that the held result does not change and that the first request offered after release is the one that gets through.

// File: rtl/sop_pkg.sv
package sop_pkg;

  typedef enum logic [1:0] {
    SH_LSL = 2'b00,
    SH_LSR = 2'b01,
    SH_ASR = 2'b10,
    SH_ROR = 2'b11
  } shift_kind_e;

  typedef struct packed {
    shift_kind_e kind;
    logic        rrx;    // rotate one place through carry
  } shift_ctrl_t;

endpackage

// File: rtl/sop_decode.sv
module sop_decode
  import sop_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int AMT_W      = 8,
  parameter int PC_IMM_OFS = 8,
  parameter int PC_REG_OFS = 12
) (
  input  logic [31:0]       instr,
  input  logic [DATA_W-1:0] rm_val,
  input  logic [DATA_W-1:0] rs_val,
  input  logic [DATA_W-1:0] pc,
  output logic [DATA_W-1:0] value,
  output logic [AMT_W-1:0]  amount,
  output shift_ctrl_t       ctrl
);

  logic       const_form;
  logic       amt_from_reg;
  logic [4:0] imm_amt;
  logic       rm_is_pc;
  logic       unused_bits;

  assign const_form   = instr[25];
  assign amt_from_reg = instr[4];
  assign imm_amt      = instr[11:7];
  assign rm_is_pc     = (instr[3:0] == 4'hF);
  assign unused_bits  = ^{instr[31:26], instr[24:12], rs_val[DATA_W-1:AMT_W]};

  always_comb begin
    value     = rm_val;
    amount    = '0;
    ctrl.kind = shift_kind_e'(instr[6:5]);
    ctrl.rrx  = 1'b0;
    if (const_form) begin
      value     = DATA_W'(instr[7:0]);
      amount    = AMT_W'({instr[11:8], 1'b0});
      ctrl.kind = SH_ROR;
    end else begin
      if (rm_is_pc) begin
        value = pc + (amt_from_reg ? DATA_W'(PC_REG_OFS) : DATA_W'(PC_IMM_OFS));
      end
      if (amt_from_reg) begin
        amount = rs_val[AMT_W-1:0];
      end else if (imm_amt != 5'd0) begin
        amount = AMT_W'(imm_amt);
      end else begin
        unique case (ctrl.kind)
          SH_LSL:         amount = '0;
          SH_LSR, SH_ASR: amount = AMT_W'(DATA_W);
          SH_ROR:         ctrl.rrx = 1'b1;
          default:        amount = '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/sop_rotator.sv
module sop_rotator #(
  parameter int DATA_W = 32,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] value,
  input  logic [SH_W-1:0]   rot,
  output logic [DATA_W-1:0] result
);

  logic [DATA_W-1:0] stage [SH_W+1];

  assign stage[0] = value;

  for (genvar s = 0; s < SH_W; s++) begin : g_stage
    localparam int STEP = 1 << s;
    assign stage[s+1] = rot[s]
      ? {stage[s][STEP-1:0], stage[s][DATA_W-1:STEP]}
      : stage[s];
  end

  assign result = stage[SH_W];

endmodule

// File: rtl/sop_shift_core.sv
module sop_shift_core
  import sop_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] value,
  input  logic [AMT_W-1:0]  amount,
  input  shift_ctrl_t       ctrl,
  input  logic              carry_in,
  output logic [DATA_W-1:0] result,
  output logic              carry_out
);

  logic [DATA_W:0]        lsl_ext;
  logic [DATA_W:0]        lsr_ext;
  logic [DATA_W:0]        asr_ext;
  logic signed [DATA_W:0] asr_in;
  logic [AMT_W-1:0]       asr_n;
  logic [DATA_W-1:0]      ror_res;

  // Carry bit rides one position beyond the shifted word.
  assign lsl_ext = {1'b0, value} << amount;
  assign lsr_ext = {value, 1'b0} >> amount;
  assign asr_in  = {value, 1'b0};
  assign asr_n   = (amount > AMT_W'(DATA_W)) ? AMT_W'(DATA_W) : amount;
  assign asr_ext = asr_in >>> asr_n;

  sop_rotator #(.DATA_W(DATA_W)) u_rot (
    .value  (value),
    .rot    (amount[SH_W-1:0]),
    .result (ror_res)
  );

  always_comb begin
    result    = value;
    carry_out = carry_in;
    if (ctrl.rrx) begin
      result    = {carry_in, value[DATA_W-1:1]};
      carry_out = value[0];
    end else if (amount != '0) begin
      unique case (ctrl.kind)
        SH_LSL: {carry_out, result} = lsl_ext;
        SH_LSR: {result, carry_out} = lsr_ext;
        SH_ASR: {result, carry_out} = asr_ext;
        SH_ROR: begin
          result    = ror_res;
          carry_out = ror_res[DATA_W-1];
        end
        default: begin
          result    = value;
          carry_out = carry_in;
        end
      endcase
    end
  end

endmodule

// File: rtl/sop_out_stage.sv
module sop_out_stage #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] d_operand,
  input  logic              d_carry,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] q_operand,
  output logic              q_carry
);

  logic take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      q_operand <= '0;
      q_carry   <= 1'b0;
    end else begin
      if (take) begin
        out_valid <= 1'b1;
        q_operand <= d_operand;
        q_carry   <= d_carry;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/shifter_operand_unit.sv
module shifter_operand_unit
  import sop_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int AMT_W      = 8,
  parameter int PC_IMM_OFS = 8,
  parameter int PC_REG_OFS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [31:0]       instr,
  input  logic [DATA_W-1:0] rm_val,
  input  logic [DATA_W-1:0] rs_val,
  input  logic [DATA_W-1:0] pc,
  input  logic              carry_in,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] operand,
  output logic              carry_out
);

  logic [DATA_W-1:0] src_value;
  logic [AMT_W-1:0]  src_amount;
  shift_ctrl_t       src_ctrl;
  logic [DATA_W-1:0] sh_result;
  logic              sh_carry;

  sop_decode #(
    .DATA_W(DATA_W), .AMT_W(AMT_W),
    .PC_IMM_OFS(PC_IMM_OFS), .PC_REG_OFS(PC_REG_OFS)
  ) u_decode (
    .instr  (instr),
    .rm_val (rm_val),
    .rs_val (rs_val),
    .pc     (pc),
    .value  (src_value),
    .amount (src_amount),
    .ctrl   (src_ctrl)
  );

  sop_shift_core #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_core (
    .value     (src_value),
    .amount    (src_amount),
    .ctrl      (src_ctrl),
    .carry_in  (carry_in),
    .result    (sh_result),
    .carry_out (sh_carry)
  );

  sop_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .d_operand (sh_result),
    .d_carry   (sh_carry),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .q_operand (operand),
    .q_carry   (carry_out)
  );

endmodule

// File: rtl/sop_checker.sv
module sop_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [31:0]       instr,
  input logic [DATA_W-1:0] rm_val,
  input logic [DATA_W-1:0] rs_val,
  input logic [DATA_W-1:0] pc,
  input logic              carry_in,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] operand,
  input logic              carry_out
);

  logic accept;
  logic plain_rm;
  assign accept   = in_valid && in_ready;
  assign plain_rm = !instr[25] && (instr[3:0] != 4'hF);

  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(operand) && $stable(carry_out)));

  // R11
  accept_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);

  // R3
  lsl_zero_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && plain_rm && !instr[4] && instr[11:7] == 5'd0 && instr[6:5] == 2'b00)
    |=> (operand == $past(rm_val) && carry_out == $past(carry_in)));

  // R4
  lsr_zero_is_32_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && plain_rm && !instr[4] && instr[11:7] == 5'd0 && instr[6:5] == 2'b01)
    |=> (operand == '0 && carry_out == $past(rm_val[DATA_W-1])));

  // R7
  reg_zero_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && plain_rm && instr[4] && rs_val[7:0] == 8'd0)
    |=> (operand == $past(rm_val) && carry_out == $past(carry_in)));

  // R10
  pc_imm_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !instr[25] && instr[3:0] == 4'hF && !instr[4] &&
     instr[11:7] == 5'd0 && instr[6:5] == 2'b00)
    |=> (operand == $past(pc) + DATA_W'(8)));

  // R12
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |-> !out_valid);

endmodule

bind shifter_operand_unit sop_checker #(.DATA_W(DATA_W)) u_sop_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .instr     (instr),
  .rm_val    (rm_val),
  .rs_val    (rs_val),
  .pc        (pc),
  .carry_in  (carry_in),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .operand   (operand),
  .carry_out (carry_out)
);

// File: tb/test_shifter_operand_unit.sv
module test_shifter_operand_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] instr = '0;
  logic [31:0] rm_val = '0;
  logic [31:0] rs_val = '0;
  logic [31:0] pc = '0;
  logic        carry_in = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] operand;
  logic        carry_out;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  shifter_operand_unit i_shifter_operand_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .instr(instr), .rm_val(rm_val), .rs_val(rs_val), .pc(pc),
    .carry_in(carry_in), .out_valid(out_valid), .out_ready(out_ready),
    .operand(operand), .carry_out(carry_out)
  );

  // {req, instr, rm_val, rs_val, pc, carry_in, exp_operand, exp_carry}
  localparam int NV = 28;
  localparam logic [165:0] VEC [NV] = '{
    {4'd6,  32'h0000_0202, 32'h1000_000F, 32'hDEAD_0000, 32'h0, 1'b0, 32'h0000_00F0, 1'b1}, // R6 lsl #4
    {4'd3,  32'h0000_0002, 32'hDEAD_BEEF, 32'h0000_0004, 32'h0, 1'b1, 32'hDEAD_BEEF, 1'b1}, // R3 lsl #0
    {4'd3,  32'h0000_0002, 32'h1234_5678, 32'h0,         32'h0, 1'b0, 32'h1234_5678, 1'b0}, // R3 carry kept 0
    {4'd4,  32'h0000_0022, 32'h8000_0001, 32'h0,         32'h0, 1'b0, 32'h0000_0000, 1'b1}, // R4 lsr #0
    {4'd6,  32'h0000_00A2, 32'h0000_0003, 32'h0,         32'h0, 1'b0, 32'h0000_0001, 1'b1}, // R6 lsr #1
    {4'd4,  32'h0000_0042, 32'h8000_0000, 32'h0,         32'h0, 1'b0, 32'hFFFF_FFFF, 1'b1}, // R4 asr #0
    {4'd6,  32'h0000_0242, 32'hF000_0008, 32'h0,         32'h0, 1'b0, 32'hFF00_0000, 1'b1}, // R6 asr #4
    {4'd5,  32'h0000_0062, 32'h0000_0003, 32'h0,         32'h0, 1'b1, 32'h8000_0001, 1'b1}, // R5 rrx c=1
    {4'd5,  32'h0000_0062, 32'h8000_0002, 32'h0,         32'h0, 1'b0, 32'h4000_0001, 1'b0}, // R5 rrx c=0
    {4'd6,  32'h0000_0462, 32'h1234_5678, 32'h0,         32'h0, 1'b1, 32'h7812_3456, 1'b0}, // R6 ror #8
    {4'd7,  32'h0000_0312, 32'h0F0F_0F0F, 32'hFFFF_FF00, 32'h0, 1'b1, 32'h0F0F_0F0F, 1'b1}, // R7 R2 lsl reg 0
    {4'd7,  32'h0000_0372, 32'h0000_0055, 32'h0000_0100, 32'h0, 1'b0, 32'h0000_0055, 1'b0}, // R7 R2 ror reg 0
    {4'd7,  32'h0000_0352, 32'h8000_0000, 32'h0000_0000, 32'h0, 1'b1, 32'h8000_0000, 1'b1}, // R7 asr reg 0
    {4'd8,  32'h0000_0312, 32'h0000_0001, 32'h0000_0020, 32'h0, 1'b0, 32'h0000_0000, 1'b1}, // R8 lsl 32
    {4'd8,  32'h0000_0312, 32'hFFFF_FFFF, 32'h0000_0021, 32'h0, 1'b1, 32'h0000_0000, 1'b0}, // R8 lsl 33
    {4'd6,  32'h0000_0312, 32'h0000_0003, 32'h0000_001F, 32'h0, 1'b0, 32'h8000_0000, 1'b1}, // R6 lsl reg 31
    {4'd8,  32'h0000_0332, 32'h8000_0000, 32'h0000_0020, 32'h0, 1'b0, 32'h0000_0000, 1'b1}, // R8 lsr 32
    {4'd8,  32'h0000_0332, 32'hFFFF_FFFF, 32'h0000_0028, 32'h0, 1'b1, 32'h0000_0000, 1'b0}, // R8 lsr 40
    {4'd6,  32'h0000_0332, 32'h0000_00F8, 32'hAB00_0004, 32'h0, 1'b0, 32'h0000_000F, 1'b1}, // R6 R2 lsr reg 4
    {4'd9,  32'h0000_0352, 32'h8000_0000, 32'h0000_0064, 32'h0, 1'b0, 32'hFFFF_FFFF, 1'b1}, // R9 asr 100
    {4'd9,  32'h0000_0352, 32'h7FFF_FFFF, 32'h0000_0040, 32'h0, 1'b1, 32'h0000_0000, 1'b0}, // R9 asr 64
    {4'd9,  32'h0000_0372, 32'h8000_0001, 32'h0000_0020, 32'h0, 1'b0, 32'h8000_0001, 1'b1}, // R9 ror 32
    {4'd6,  32'h0000_0372, 32'h0000_000F, 32'h0000_0024, 32'h0, 1'b0, 32'hF000_0000, 1'b1}, // R6 ror 36
    {4'd1,  32'h0200_00AB, 32'hFFFF_FFFF, 32'h0,         32'h0, 1'b1, 32'h0000_00AB, 1'b1}, // R1 rot 0
    {4'd1,  32'h0200_04FF, 32'h0,         32'h0,         32'h0, 1'b0, 32'hFF00_0000, 1'b1}, // R1 rot 8
    {4'd1,  32'h0200_0101, 32'h0,         32'h0,         32'h0, 1'b1, 32'h4000_0000, 1'b0}, // R1 rot 2
    {4'd10, 32'h0000_000F, 32'h0000_DEAD, 32'h0,  32'h0000_1000, 1'b0, 32'h0000_1008, 1'b0}, // R10 pc+8
    {4'd10, 32'h0000_031F, 32'h0000_DEAD, 32'h1,  32'h8000_0000, 1'b0, 32'h0000_0018, 1'b1}  // R10 pc+12 lsl 1
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] i, input logic [31:0] rm, input logic [31:0] rs,
                       input logic [31:0] p, input logic c);
    instr = i; rm_val = rm; rs_val = rs; pc = p; carry_in = c;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    // R12: reset state
    repeat (3) @(negedge clk);
    chk("R12 out_valid in reset", {31'b0, out_valid}, 32'd0);
    chk("R11 in_ready in reset", {31'b0, in_ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 out_valid after reset", {31'b0, out_valid}, 32'd0);

    // Vector table
    for (int k = 0; k < NV; k++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VEC[k][165:162], k);
      drive(VEC[k][161:130], VEC[k][129:98], VEC[k][97:66], VEC[k][65:34], VEC[k][33]);
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk({tag, " valid"}, {31'b0, out_valid}, 32'd1);
      chk({tag, " operand"}, operand, VEC[k][32:1]);
      chk({tag, " carry"}, {31'b0, carry_out}, {31'b0, VEC[k][0]});
    end

    // R11: back-pressure hold
    @(negedge clk);
    out_ready = 1'b0;
    drive(32'h0000_0202, 32'h1000_000F, 32'h0, 32'h0, 1'b0); // -> F0, c=1
    in_valid = 1'b1;
    @(negedge clk);
    chk("R11 held valid", {31'b0, out_valid}, 32'd1);
    chk("R11 in_ready low under stall", {31'b0, in_ready}, 32'd0);
    drive(32'h0000_0022, 32'hFFFF_FFFF, 32'h0, 32'h0, 1'b0); // would give 0, c=1
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      chk("R11 operand held", operand, 32'h0000_00F0);
      chk("R11 carry held", {31'b0, carry_out}, 32'd1);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R11 next request after release", operand, 32'h0000_0000);
    chk("R11 next carry after release", {31'b0, carry_out}, 32'd1);
    @(negedge clk);
    chk("R11 drained", {31'b0, out_valid}, 32'd0);

    // R10 with immediate logical-right of PC
    drive(32'h0000_00AF, 32'h0, 32'h0, 32'h0000_0100, 1'b1);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R10 pc+8 lsr 1", operand, 32'h0000_0084);
    chk("R10 pc+8 lsr 1 carry", {31'b0, carry_out}, 32'd0);

    // R12: reset while a result is pending
    out_ready = 1'b0;
    drive(32'h0000_0002, 32'h5, 32'h0, 32'h0, 1'b0);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    chk("R12 reset clears result", {31'b0, out_valid}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    out_ready = 1'b1;
    @(negedge clk);

    done = 1'b1;
    finish_run();
  end

endmodule